// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block sits between a clocked host and a 16-bit asynchronous pseudo-static RAM. The host asks for one word at a time, either a read or a write with a per-byte mask. The controller turns each request into a pin sequence whose phase lengths are whole clock cycles. Each length is the ceiling of a nanosecond figure for the chosen speed grade (55, 60 or 70 ns) divided by the clock period parameter.

Every access drops chip enable only after the address has been on the pins for one full clock. Reads are chip-enable controlled, with output enable falling together with chip enable. Writes keep output enable high throughout. The controller drives the data bus from the fall of write enable until one clock after its rise. After every access, chip enable is held high for at least one read-cycle time. A long run of chip-enable-low with a changing address therefore cannot occur, which keeps the memory's internal refresh satisfied. The same recovery is applied once after reset. Busy covers the whole sequence, and a request presented while busy is dropped.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held and after its release, chip enable, write enable, output enable and both byte-lane strobes are high and the data bus is not driven. Busy stays high for exactly CEH_CYC = ceil(GRADE_NS / CLK_NS) clocks after reset release before the first request can be taken.
- R2: A read puts the address on the pins one clock before chip enable falls and keeps it unchanged while chip enable is low. Chip enable and output enable are then low together, with write enable high, for RD_CYC clocks.
- R3: Read data is sampled from the bus on the last clock edge of the chip-enable-low window. It is presented on the read data output with a read-valid pulse exactly one clock wide.
- R4: A write holds chip enable and write enable low together for WR_CYC clocks. Output enable stays high whenever write enable is low.
- R5: The controller drives the data bus from the first write-enable-low cycle through one clock after write enable rises, which is WR_CYC + 1 clocks. At all other times the bus is left floating.
- R6: Byte-enable bit 0 selects the low lane (data bits 7:0) and bit 1 the high lane (bits 15:8). Each lane strobe is pulled low only inside the chip-enable-low window and only when its bit is set. A write with a lane disabled leaves that byte of the memory word unchanged. Both strobes are high whenever chip enable is high.
- R7: Chip enable is high for at least CEH_CYC clocks before every fall. Chip enable never stays low for 15 us or longer. A request raised while busy is high is ignored and starts no access.
- R8: The phase lengths are whole-cycle ceilings:
  - RD_CYC = ceil(max(grade, output-enable access) / CLK_NS), where the output-enable access is 35 ns for the 70 ns grade and 25 ns otherwise.
  - WR_CYC = ceil(max(grade, write pulse, 25 ns data setup) / CLK_NS), where the write pulse is 45 ns for the 70 ns grade and 40 ns otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request strobe, taken when busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address |
| host_wdata | input | DW | Write data |
| host_be | input | DW/8 | Byte-lane enables, bit 0 = low byte |
| host_busy | output | 1 | High while an access or the recovery is in progress |
| host_rvalid | output | 1 | One-clock pulse marking valid read data |
| host_rdata | output | DW | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bsel_n | output | DW/8 | Byte-lane strobes, active low, bit 0 = low byte |
| mem_addr | output | AW | Memory address |
| mem_dq | inout | DW | Bidirectional data bus |

## Verification
The bench measures each chip-enable-low, write-enable-low and bus-drive window and compares it with lengths it derives on its own from the speed grade. An off-by-one in the timer or a missing write-end hold cycle would therefore show up as a window one clock short or long. It issues partial-lane writes and reads the merged word back, so a swapped or always-on lane strobe would corrupt the untouched byte. A request raised in the middle of a busy write is checked to leave its target word alone and to start no extra access; a controller that latched it would write the wrong word. The bench also records the shortest chip-enable-high gap and any address movement or output-enable overlap, which catches a missing recovery phase, an address launched together with chip enable, or a read enable leaking into a write.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WRITE,
    ST_WHOLD,
    ST_RECOV
  } pstate_e;

  localparam int DATA_SETUP_NS = 25;
  localparam int REFRESH_WIN_NS = 15000;

  function automatic int ceil_div(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int oe_access_ns(input int grade);
    return (grade >= 70) ? 35 : 25;
  endfunction

  function automatic int we_pulse_ns(input int grade);
    return (grade >= 70) ? 45 : 40;
  endfunction

  function automatic int rd_cycles(input int grade, input int per);
    return ceil_div(imax(grade, oe_access_ns(grade)), per);
  endfunction

  function automatic int wr_cycles(input int grade, input int per);
    return ceil_div(imax(imax(grade, we_pulse_ns(grade)), DATA_SETUP_NS), per);
  endfunction

  function automatic int ceh_cycles(input int grade, input int per);
    return imax(ceil_div(grade, per), 1);
  endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
  parameter int CW      = 4,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= CW'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R8: a loaded nonzero count must take at least one more cycle to expire
  assert_timer_load_R8: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/psram_fsm.sv
module psram_fsm
  import psram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 9,
  parameter int WR_CYC  = 9,
  parameter int CEH_CYC = 9,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          rd_last,
  output logic          lane_act_nxt,
  output logic          busy,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);

  pstate_e state, nxt;
  logic    wr_q;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    rd_last  = 1'b0;
    unique case (state)
      ST_IDLE: if (req) begin
        nxt    = ST_SETUP;
        accept = 1'b1;
      end
      ST_SETUP: begin
        nxt      = wr_q ? ST_WRITE : ST_READ;
        tmr_load = 1'b1;
        tmr_val  = wr_q ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
      end
      ST_READ: if (tmr_zero) begin
        nxt      = ST_RECOV;
        rd_last  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CW'(CEH_CYC - 1);
      end
      ST_WRITE: if (tmr_zero) nxt = ST_WHOLD;
      ST_WHOLD: begin
        nxt      = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = CW'(CEH_CYC - 1);
      end
      ST_RECOV: if (tmr_zero) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  // pins are registered from the next state so they change only on clock edges
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RECOV;
      wr_q  <= 1'b0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) wr_q <= req_we;
      ce_n  <= !(nxt == ST_READ || nxt == ST_WRITE);
      we_n  <= (nxt != ST_WRITE);
      oe_n  <= (nxt != ST_READ);
      dq_oe <= (nxt == ST_WRITE || nxt == ST_WHOLD);
    end
  end

  assign busy         = (state != ST_IDLE);
  assign lane_act_nxt = (nxt == ST_READ) || (nxt == ST_WRITE);

  // R2: chip enable only falls after a full address setup cycle
  assert_ce_after_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ce_n) |-> $past(state) == ST_SETUP);

  // R5: bus stays driven for one cycle after write enable rises
  assert_dq_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> dq_oe);

endmodule

// File: rtl/psram_io.sv
module psram_io #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_be,
  input  logic          lane_act_nxt,
  input  logic          dq_oe,
  input  logic          rd_last,
  output logic [AW-1:0] mem_addr,
  output logic [NB-1:0] mem_bsel_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  inout  wire  [DW-1:0] mem_dq
);

  logic [DW-1:0] wdata_q;
  logic [NB-1:0] be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      mem_bsel_n <= '1;
      rdata      <= '0;
      rvalid     <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        wdata_q  <= req_wdata;
        be_q     <= req_be;
      end
      mem_bsel_n <= lane_act_nxt ? ~be_q : '1;
      rvalid     <= rd_last;
      if (rd_last) rdata <= mem_dq;
    end
  end

  assign mem_dq = dq_oe ? wdata_q : 'z;

  // R3: read data does not move between captures
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_last) |-> $stable(rdata));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_NS   = 8,
  parameter int GRADE_NS = 70,
  parameter int AW       = 18,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW/8-1:0] host_be,
  output logic          host_busy,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW/8-1:0] mem_bsel_n,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq
);

  localparam int NB      = DW / 8;
  localparam int RD_CYC  = rd_cycles(GRADE_NS, CLK_NS);
  localparam int WR_CYC  = wr_cycles(GRADE_NS, CLK_NS);
  localparam int CEH_CYC = ceh_cycles(GRADE_NS, CLK_NS);
  localparam int MAXCYC  = imax(imax(RD_CYC, WR_CYC), CEH_CYC);
  localparam int CW      = $clog2(MAXCYC + 1);
  localparam int LOW_LIM = ceil_div(REFRESH_WIN_NS, CLK_NS);
  localparam int LW      = $clog2(LOW_LIM + 2);
  localparam int GW      = $clog2(MAXCYC + 3);

  logic          tmr_load, tmr_zero, accept, rd_last, lane_act_nxt, dq_oe;
  logic [CW-1:0] tmr_val;

  psram_timer #(.CW(CW), .RST_VAL(CEH_CYC - 1)) timer_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  psram_fsm #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .CEH_CYC(CEH_CYC), .CW(CW)) fsm_i (
    .clk(clk), .rst(rst), .req(host_req), .req_we(host_we), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept), .rd_last(rd_last),
    .lane_act_nxt(lane_act_nxt), .busy(host_busy), .ce_n(mem_ce_n), .we_n(mem_we_n),
    .oe_n(mem_oe_n), .dq_oe(dq_oe)
  );

  psram_io #(.AW(AW), .DW(DW), .NB(NB)) io_i (
    .clk(clk), .rst(rst), .accept(accept), .req_addr(host_addr), .req_wdata(host_wdata),
    .req_be(host_be), .lane_act_nxt(lane_act_nxt), .dq_oe(dq_oe), .rd_last(rd_last),
    .mem_addr(mem_addr), .mem_bsel_n(mem_bsel_n), .rdata(host_rdata),
    .rvalid(host_rvalid), .mem_dq(mem_dq)
  );

  // pin-level run-length counters used by the timing assertions
  logic [GW-1:0] ceh_run, we_run;
  logic [LW-1:0] ce_low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ceh_run    <= '0;
      we_run     <= '0;
      ce_low_run <= '0;
    end else begin
      if (!mem_ce_n)                       ceh_run <= '0;
      else if (ceh_run != GW'(MAXCYC + 2)) ceh_run <= ceh_run + 1'b1;
      if (mem_we_n)                        we_run <= '0;
      else if (we_run != GW'(MAXCYC + 2))  we_run <= we_run + 1'b1;
      if (mem_ce_n)                        ce_low_run <= '0;
      else if (ce_low_run != LW'(LOW_LIM + 1)) ce_low_run <= ce_low_run + 1'b1;
    end
  end

  assert_ce_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> ceh_run >= GW'(CEH_CYC));

  assert_ce_low_bound_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> ce_low_run < LW'(LOW_LIM));

  assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> we_run == GW'(WR_CYC));

  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  assert_no_bus_fight_R5: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> mem_oe_n);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  assert_lanes_idle_R6: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> (mem_bsel_n == '1));

  assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_busy) |=> $stable(mem_addr));

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_oe));

endmodule

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb_top;

  localparam int CLK_NS = 8;
  localparam int GRADE  = 70;
  localparam int AW     = 18;
  localparam int DW     = 16;

  function automatic int up_div(input int a, input int b);
    return a / b + ((a % b) != 0 ? 1 : 0);
  endfunction

  localparam int OE_NS   = (GRADE == 70) ? 35 : 25;
  localparam int WP_NS   = (GRADE == 70) ? 45 : 40;
  localparam int EXP_RD  = up_div((GRADE > OE_NS) ? GRADE : OE_NS, CLK_NS);
  localparam int EXP_WR  = up_div((GRADE > WP_NS) ? GRADE : WP_NS, CLK_NS);
  localparam int EXP_CEH = up_div(GRADE, CLK_NS);
  localparam int LOW_LIM = up_div(15000, CLK_NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [1:0] host_be = 2'b00;
  logic host_busy, host_rvalid;
  logic [DW-1:0] host_rdata;
  logic mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0] mem_bsel_n;
  logic [AW-1:0] mem_addr;
  tri   [DW-1:0] mem_dq;

  always #4 clk = ~clk;

  psram_ctrl #(.CLK_NS(CLK_NS), .GRADE_NS(GRADE), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be), .host_busy(host_busy),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_bsel_n(mem_bsel_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  // memory model, 256 words, address aliased on the low byte
  logic [DW-1:0] mem [0:255];
  wire model_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq[7:0]  = (model_drv && !mem_bsel_n[0]) ? mem[mem_addr[7:0]][7:0]  : 8'hzz;
  assign mem_dq[15:8] = (model_drv && !mem_bsel_n[1]) ? mem[mem_addr[7:0]][15:8] : 8'hzz;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_bsel_n[0]) mem[mem_addr[7:0]][7:0]  <= mem_dq[7:0];
      if (!mem_bsel_n[1]) mem[mem_addr[7:0]][15:8] <= mem_dq[15:8];
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // pin monitor, sampled on the falling edge
  int cur_ce = 0, last_ce = 0, cur_we = 0, last_we = 0, cur_drv = 0, last_drv = 0;
  int cur_hi = 0, min_gap = 1000000, ce_falls = 0, max_ce_low = 0, rv_cnt = 0;
  int addr_err = 0, setup_err = 0, overlap_err = 0, lane_err = 0;
  logic [AW-1:0] prev_addr = '0;
  logic prev_ce = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce_n) begin
        if (prev_ce) begin
          ce_falls++;
          if (cur_hi < min_gap) min_gap = cur_hi;
          if (mem_addr !== prev_addr) setup_err++;
        end else if (mem_addr !== prev_addr) addr_err++;
        cur_ce++;
        cur_hi = 0;
        if (cur_ce > max_ce_low) max_ce_low = cur_ce;
      end else begin
        if (cur_ce > 0) last_ce = cur_ce;
        cur_ce = 0;
        cur_hi++;
        if (mem_bsel_n !== 2'b11) lane_err++;
      end
      if (!mem_we_n) cur_we++;
      else begin
        if (cur_we > 0) last_we = cur_we;
        cur_we = 0;
      end
      if (!mem_we_n && !mem_oe_n) overlap_err++;
      if ((mem_dq !== 16'hzzzz) && !model_drv) cur_drv++;
      else begin
        if (cur_drv > 0) last_drv = cur_drv;
        cur_drv = 0;
      end
      if (host_rvalid) rv_cnt++;
    end
    prev_ce   = mem_ce_n;
    prev_addr = mem_addr;
  end

  task automatic wait_idle();
    while (host_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d; host_be = be;
    @(negedge clk);
    host_req = 1'b0;
    wait_idle();
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    int rv0;
    rv0 = rv_cnt;
    d = 'x;
    host_req = 1'b1; host_we = 1'b0; host_addr = a; host_be = 2'b11;
    @(negedge clk);
    host_req = 1'b0;
    while (host_busy) begin
      if (host_rvalid) d = host_rdata;
      @(negedge clk);
    end
    @(negedge clk);
    check("R3", "one rvalid pulse per read", rv_cnt - rv0, 1);
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    check("R1", "pins idle in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n}, 5'b11111);
    check("R1", "bus floating in reset", mem_dq, 16'hzzzz);
    rst = 1'b0;
    n = 0;
    while (host_busy) begin n++; @(negedge clk); end
    check("R1", "busy cycles after reset", n, EXP_CEH);
    check("R1", "pins idle after reset", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
  endtask

  task automatic t_write_full();
    int f0;
    f0 = ce_falls;
    do_write(18'h00012, 16'hA5C3, 2'b11);
    check("R8", "write ce low width", last_ce, EXP_WR);
    check("R4", "write we low width", last_we, EXP_WR);
    check("R5", "bus drive width", last_drv, EXP_WR + 1);
    check("R5", "bus floating when idle", mem_dq, 16'hzzzz);
    check("R4", "one access per write", ce_falls - f0, 1);
    check("R4", "memory word written", mem[8'h12], 16'hA5C3);
  endtask

  task automatic t_read();
    logic [DW-1:0] d;
    do_read(18'h00012, d);
    check("R3", "read data", d, 16'hA5C3);
    check("R8", "read ce low width", last_ce, EXP_RD);
    check("R2", "address setup before ce fall", setup_err, 0);
  endtask

  task automatic t_bytes();
    logic [DW-1:0] d;
    do_write(18'h00020, 16'h1111, 2'b11);
    do_write(18'h00020, 16'h22EE, 2'b01);
    do_read(18'h00020, d);
    check("R6", "low lane only write", d, 16'h11EE);
    do_write(18'h00020, 16'h7700, 2'b10);
    do_read(18'h00020, d);
    check("R6", "high lane only write", d, 16'h77EE);
    do_write(18'h00020, 16'h0000, 2'b00);
    do_read(18'h00020, d);
    check("R6", "no lane write leaves word", d, 16'h77EE);
    check("R6", "lanes high while ce high", lane_err, 0);
  endtask

  task automatic t_patterns();
    logic [DW-1:0] d;
    for (int i = 0; i < 8; i++)
      do_write(AW'(1 << i), 16'h0101 * DW'(i + 1) ^ 16'hF00F, 2'b11);
    for (int i = 0; i < 8; i++) begin
      do_read(AW'(1 << i), d);
      check("R3", "pattern readback", d, 16'h0101 * DW'(i + 1) ^ 16'hF00F);
    end
  endtask

  task automatic t_ignored();
    logic [DW-1:0] d;
    int f0;
    f0 = ce_falls;
    host_req = 1'b1; host_we = 1'b1; host_addr = 18'h00040; host_wdata = 16'h1234; host_be = 2'b11;
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    host_req = 1'b1; host_addr = 18'h00041; host_wdata = 16'hDEAD;
    @(negedge clk);
    host_req = 1'b0;
    wait_idle();
    check("R7", "request while busy starts no access", ce_falls - f0, 1);
    check("R7", "ignored write left word", mem[8'h41], 16'h0000);
    do_read(18'h00040, d);
    check("R7", "accepted write landed", d, 16'h1234);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    t_reset();
    t_write_full();
    t_read();
    t_bytes();
    t_patterns();
    t_ignored();
    check("R7", "min ce high gap", (min_gap >= EXP_CEH) ? 1 : 0, 1);
    check("R7", "ce low below refresh window", (max_ce_low < LOW_LIM) ? 1 : 0, 1);
    check("R2", "address stable while ce low", addr_err, 0);
    check("R4", "oe never low with we low", overlap_err, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule